// File: doc/BRIEF.md
# Multi-Length Polynomial Noise Source

This block produces the raw 1-bit waveforms of a four-voice sound generator. Three free-running linear feedback shift registers (a long one of 17 bits, a middle one of 5 bits and a small one of 4 bits) advance on every system clock, whatever the channels are doing. A global mode input shortens the long register to 9 bits.

Each channel owns a one-bit sample-and-hold register. It may change only on a cycle where that channel's divider pulse is high, so its output can never change faster than the pulse rate. In effect, the divider acts as a low-pass clock on the noise. The upper three bits of the channel's control byte set what is captured. The choices are a square wave that flips on every accepted pulse, or a bit of the long or small register. A further option lets a pulse through only while the middle register's output is high. The registers are shared, but each channel samples them at its own rate. Each channel therefore behaves as if it had a private noise generator. Filtering and volume scaling happen downstream.

Top module: `poly_noise_source`

## Requirements
- R1: A synchronous active-high reset sets every shift register to all ones and every channel output to 0.
- R2: In full-length mode, the long register advances every clock. Its new bit 16 is bit 0 XOR bit 5, and the other bits shift down one place. Its output is bit 0. The middle and small registers behave the same way at every clock: the middle register has 5 bits, inserts at bit 4 and uses tap bit 3, and the small register has 4 bits, inserts at bit 3 and uses tap bit 3. Each output is bit 0.
- R3: While `long_short` is 1, bits 8:0 of the long register form a 9-bit register. Its new bit 8 is bit 0 XOR bit 4, and bits 8:1 shift down. Bits 16:9 hold their values.
- R4: A channel whose control bit 6 is 1 (and bit 5 is 0) captures the small register's output bit.
- R5: If every bit of a register's active window is 0, the bit inserted at the top is 1 instead of the XOR.
- R6: A channel output changes only at the clock edge that samples that channel's `div_pulse` bit high. It shows the new value from the next cycle on.
- R7: When control bit 7 is 1, a pulse is accepted only if the middle register's output is 1 in that cycle. Otherwise the channel output holds.
- R8: When control bit 5 is 1, an accepted pulse inverts the channel output. Bit 5 takes priority over bit 6.
- R9: When control bit 5 is 0, an accepted pulse loads the selected register's output bit as it was before that clock edge's advance. The long register's bit is used when bit 6 is 0.
- R10: The channels are independent. Channel i uses `div_pulse[i]` and `chan_ctl[8i+7:8i]` only.
- R11: Control bits 4:0 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers advance on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| div_pulse | input | 4 | One-cycle divider pulse per channel, bit i for channel i |
| chan_ctl | input | 32 | Control byte per channel, channel i in bits 8i+7:8i (bit 7 middle-register gate, bit 6 small-register select, bit 5 square wave) |
| long_short | input | 1 | 1 shortens the long register to 9 bits |
| chan_wave | output | 4 | Held 1-bit waveform per channel |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. A pulse sampled at a rising edge changes `chan_wave` right after that edge. The register bit it captures is the one present before that same edge. The bench drives each cycle's inputs at the falling edge. It then steps a behavioural model of the three registers and four channels to predict the outputs after the next rising edge. At the falling edge that follows, it compares all four channel outputs with that prediction, so no comparison depends on process order at the active edge.

// File: rtl/pnoise_pkg.sv
package pnoise_pkg;

    // Default register geometry (length and feedback tap position).
    localparam int LONG_LEN   = 17;
    localparam int LONG_FB    = 5;
    localparam int SHORT_LEN  = 9;
    localparam int SHORT_FB   = 4;
    localparam int MID_LEN    = 5;
    localparam int MID_FB     = 3;
    localparam int SMALL_LEN  = 4;
    localparam int SMALL_FB   = 3;

    // Per-channel control byte; MSB first, so gate_mid is bit 7.
    typedef struct packed {
        logic       gate_mid;    // bit 7: pulse accepted only while middle output is 1
        logic       pick_small;  // bit 6: small register instead of long
        logic       square;      // bit 5: square wave, overrides bit 6
        logic [4:0] spare;       // bits 4:0: no effect here
    } chan_ctl_t;

    typedef enum logic [1:0] {
        SRC_SQUARE = 2'd0,
        SRC_SMALL  = 2'd1,
        SRC_LONG   = 2'd2
    } src_sel_t;

    // Outputs of the three shared registers as seen by a channel.
    typedef struct packed {
        logic long_bit;
        logic mid_bit;
        logic small_bit;
    } poly_taps_t;

    function automatic src_sel_t pick_source(input chan_ctl_t c);
        if (c.square)
            return SRC_SQUARE;
        else if (c.pick_small)
            return SRC_SMALL;
        else
            return SRC_LONG;
    endfunction

    function automatic logic next_hold(input src_sel_t s, input logic cur,
                                       input poly_taps_t t);
        case (s)
            SRC_SQUARE: return ~cur;
            SRC_SMALL:  return t.small_bit;
            default:    return t.long_bit;
        endcase
    endfunction

endpackage

// File: rtl/poly_lfsr.sv
module poly_lfsr #(
    parameter int W       = 17,
    parameter int TAP     = 5,
    parameter int ALT_W   = 17,
    parameter int ALT_TAP = 5,
    parameter bit HAS_ALT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic shorten,
    output logic out_bit
);

    logic [W-1:0] state;
    logic [W-1:0] nxt;
    logic         use_alt;
    logic         win_zero;
    logic         fb;

    assign use_alt = shorten & HAS_ALT;

    always_comb begin
        nxt = state;
        if (use_alt) begin
            win_zero           = ~|state[ALT_W-1:0];
            fb                 = win_zero | (state[0] ^ state[ALT_TAP]);
            nxt[ALT_W-2:0]     = state[ALT_W-1:1];
            nxt[ALT_W-1]       = fb;
        end else begin
            win_zero           = ~|state;
            fb                 = win_zero | (state[0] ^ state[TAP]);
            nxt[W-2:0]         = state[W-1:1];
            nxt[W-1]           = fb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= '1;
        else
            state <= nxt;
    end

    assign out_bit = state[0];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state != '0); // R5

    AST_LFSR_FULL_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !use_alt |=> state[W-2:0] == $past(state[W-1:1])); // R2

    if (HAS_ALT) begin : g_alt
        AST_LFSR_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
            use_alt |=> $stable(state[W-1:ALT_W])); // R3

        AST_LFSR_SHORT_SHIFT: assert property (@(posedge clk) disable iff (rst)
            use_alt |=> state[ALT_W-2:0] == $past(state[ALT_W-1:1])); // R3
    end

endmodule

// File: rtl/chan_sampler.sv
module chan_sampler
    import pnoise_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pulse,
    input  chan_ctl_t  ctl,
    input  poly_taps_t taps,
    output logic       wave
);

    src_sel_t src;
    logic     take;
    logic     hold;
    logic     hold_d;
    logic     unused_spare;

    assign unused_spare = ^ctl.spare;
    assign src    = pick_source(ctl);
    assign take   = pulse & (~ctl.gate_mid | taps.mid_bit);
    assign hold_d = next_hold(src, hold, taps);

    always_ff @(posedge clk) begin
        if (rst)
            hold <= 1'b0;
        else if (take)
            hold <= hold_d;
    end

    assign wave = hold;

    AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pulse |=> $stable(wave)); // R6

    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (pulse && ctl.gate_mid && !taps.mid_bit) |=> $stable(wave)); // R7

    AST_SQUARE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (pulse && ctl.square && !ctl.gate_mid) |=> wave != $past(wave)); // R8

    AST_NOISE_TRACK: assert property (@(posedge clk) disable iff (rst)
        (pulse && !ctl.square && !ctl.gate_mid) |=>
            wave == $past(ctl.pick_small ? taps.small_bit : taps.long_bit)); // R9

endmodule

// File: rtl/poly_noise_source.sv
module poly_noise_source
    import pnoise_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int LONG_W    = LONG_LEN,
    parameter int LONG_T    = LONG_FB,
    parameter int SHORT_W   = SHORT_LEN,
    parameter int SHORT_T   = SHORT_FB,
    parameter int MID_W     = MID_LEN,
    parameter int MID_T     = MID_FB,
    parameter int SMALL_W   = SMALL_LEN,
    parameter int SMALL_T   = SMALL_FB,
    localparam int CTL_W    = $bits(chan_ctl_t),
    localparam int CTL_ALL  = NUM_CH * CTL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CH-1:0]  div_pulse,
    input  logic [CTL_ALL-1:0] chan_ctl,
    input  logic               long_short,
    output logic [NUM_CH-1:0]  chan_wave
);

    poly_taps_t taps;

    poly_lfsr #(
        .W(LONG_W), .TAP(LONG_T), .ALT_W(SHORT_W), .ALT_TAP(SHORT_T), .HAS_ALT(1'b1)
    ) u_long (
        .clk(clk), .rst(rst), .shorten(long_short), .out_bit(taps.long_bit)
    );

    poly_lfsr #(
        .W(MID_W), .TAP(MID_T), .ALT_W(MID_W), .ALT_TAP(MID_T), .HAS_ALT(1'b0)
    ) u_mid (
        .clk(clk), .rst(rst), .shorten(1'b0), .out_bit(taps.mid_bit)
    );

    poly_lfsr #(
        .W(SMALL_W), .TAP(SMALL_T), .ALT_W(SMALL_W), .ALT_TAP(SMALL_T), .HAS_ALT(1'b0)
    ) u_small (
        .clk(clk), .rst(rst), .shorten(1'b0), .out_bit(taps.small_bit)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        chan_sampler u_chan (
            .clk  (clk),
            .rst  (rst),
            .pulse(div_pulse[ch]),
            .ctl  (chan_ctl_t'(chan_ctl[ch*CTL_W +: CTL_W])),
            .taps (taps),
            .wave (chan_wave[ch])
        );
    end

    AST_ALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (div_pulse == '0) |=> $stable(chan_wave)); // R10

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (chan_wave == '0)); // R1

endmodule

// File: tb/poly_noise_source_test.sv
module poly_noise_source_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  div_pulse;
    logic [31:0] chan_ctl;
    logic        long_short;
    logic [3:0]  chan_wave;

    int checks = 0;
    int fails  = 0;

    int    m_long, m_mid, m_small;
    bit    exp_wave [4];
    string why      [4];

    always #4 clk = ~clk;

    poly_noise_source uut (
        .clk(clk), .rst(rst), .div_pulse(div_pulse), .chan_ctl(chan_ctl),
        .long_short(long_short), .chan_wave(chan_wave)
    );

    // One register step over an n-bit window; bits above the window keep their value.
    // An all-zero window inserts a 1 (R5).
    function automatic int lstep(int s, int n, int tap);
        int mask = (1 << n) - 1;
        int win  = s & mask;
        int fb   = (win == 0) ? 1 : ((win ^ (win >> tap)) & 1);
        return (s & ~mask) | (fb << (n - 1)) | (win >> 1);
    endfunction

    task automatic check_outputs();
        for (int ch = 0; ch < 4; ch++) begin
            checks++;
            if (chan_wave[ch] !== exp_wave[ch]) begin
                fails++;
                $display("FAIL %s ch%0d: got %b expected %b", why[ch], ch,
                         chan_wave[ch], exp_wave[ch]);
            end
        end
    endtask

    // Apply inputs for the next rising edge and predict the result after it.
    task automatic drive(bit r, logic [3:0] p, logic [31:0] c, bit sh);
        int lb, mb, sb;
        rst = r; div_pulse = p; chan_ctl = c; long_short = sh;
        if (r) begin
            m_long = 32'h1FFFF; m_mid = 32'h1F; m_small = 32'hF;
            for (int ch = 0; ch < 4; ch++) begin
                exp_wave[ch] = 1'b0; why[ch] = "R1 reset";
            end
            return;
        end
        lb = m_long & 1; mb = m_mid & 1; sb = m_small & 1;
        for (int ch = 0; ch < 4; ch++) begin
            logic [7:0] b = c[ch*8 +: 8];   // R10: only this channel's byte and pulse
            if (!p[ch])
                why[ch] = "R6 no pulse";
            else if (b[7] && mb == 0)
                why[ch] = "R7 gated off";
            else if (b[5]) begin
                exp_wave[ch] = ~exp_wave[ch];
                why[ch] = "R8 square";
            end else if (b[6]) begin
                exp_wave[ch] = sb[0];
                why[ch] = "R9 R4 small noise";
            end else begin
                exp_wave[ch] = lb[0];
                why[ch] = sh ? "R9 R3 short noise" : "R9 R2 long noise";
            end
        end
        m_long  = sh ? lstep(m_long, 9, 4) : lstep(m_long, 17, 5);
        m_mid   = lstep(m_mid, 5, 3);
        m_small = lstep(m_small, 4, 3);
    endtask

    // mode: 0 square, 1 long noise, 2 small noise, 3 gated, 4 mixed per channel, 5 random
    task automatic run(int n, int mode, bit sh, bit every);
        for (int i = 0; i < n; i++) begin
            logic [3:0]  p;
            logic [31:0] c;
            bit          s = sh;
            @(negedge clk);
            check_outputs();
            for (int ch = 0; ch < 4; ch++) begin
                logic [7:0] b;
                p[ch] = every ? 1'b1 : (($urandom % (ch + 2)) == 0);
                b = 8'($urandom) & 8'h1F;   // R11: low bits vary freely
                case (mode)
                    0: b[7:5] = 3'b001;
                    1: b[7:5] = 3'b000;
                    2: b[7:5] = 3'b010;
                    3: b[7:5] = {1'b1, 2'($urandom)};
                    4: b[7:5] = (ch == 0) ? 3'b001 : (ch == 1) ? 3'b000 :
                                (ch == 2) ? 3'b010 : 3'b100;
                    default: b = 8'($urandom);
                endcase
                c[ch*8 +: 8] = b;
            end
            if (mode == 5) s = (($urandom % 8) == 0) ? ~long_short : long_short;
            drive(1'b0, p, c, s);
        end
    endtask

    task automatic do_reset(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_outputs();
            drive(1'b1, 4'hF, 32'h2020_2020, 1'b0);
        end
    endtask

    initial begin
        drive(1'b1, 4'h0, 32'h0, 1'b0);
        do_reset(3);
        run(200,  0, 1'b0, 1'b1);  // R8: pulse every cycle, toggles each cycle
        run(2000, 0, 1'b0, 1'b0);  // R8
        run(3000, 1, 1'b0, 1'b0);  // R9 R2
        run(3000, 2, 1'b0, 1'b0);  // R4
        run(3000, 1, 1'b1, 1'b0);  // R3
        run(3000, 3, 1'b0, 1'b0);  // R7
        run(3000, 4, 1'b0, 1'b0);  // R10: different setting on each channel
        do_reset(2);               // R1 mid-run
        run(20000, 5, 1'b0, 1'b0); // R5: frequent mode changes reach all-zero windows
        @(negedge clk);
        check_outputs();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule